// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block captures a parallel word and sends it out one bit per shift, last stage first. Everything runs on one fast system clock. Two slow control pins are sampled as plain data. A level-sensitive load control copies the parallel inputs into the stages for as long as it is held low. Once it is high, every rising transition of a gated shift clock moves the word one place toward the output.

The gated shift clock is the OR of two pins that are treated alike. Either pin can serve as the clock while the other acts as an active-low enable, since holding the enable high pins the gated clock high and no rising transition can occur. The last stage is driven out both true and inverted. Several copies can be chained by feeding one copy's serial output into the next copy's serial input. This builds wider parallel-to-serial converters.

Top module: `piso_shift_reg`

## Requirements
- R1: A synchronous reset clears every stage. One cycle after reset, `ser_out` reads 0 and `ser_out_n` reads 1.
- R2: While `load_n` is 0, stage i takes `par_in[i]` on every system clock edge, whatever the clock pins do. One cycle after any cycle with `load_n` low, `ser_out` equals the `par_in[W-1]` of that cycle.
- R3: With `load_n` high, a cycle in which `sclk_a | sclk_b` is 1 after being 0 in the previous cycle shifts the register toward the output. `ser_in` enters stage 0, stage i-1 moves to stage i, and `ser_out` shows the old stage W-2 after that edge.
- R4: A pin held high in two consecutive cycles blocks any shift in the second cycle. Toggling the other pin then leaves the outputs unchanged.
- R5: The two clock pins are interchangeable. Swapping the clock and enable roles gives the same output sequence.
- R6: `ser_out_n` is always the complement of `ser_out`.
- R7: A gated-clock rise in the same cycle that `load_n` goes from 0 to 1 causes no shift.
- R8: With `load_n` high and no gated-clock rise, the contents hold. This covers a steady-high gated clock and a falling gated clock.
- R9: After a load, the first edges show the loaded word as bits W-1, W-2, ..., 0. After edge W+k, the output shows the `ser_in` bit applied at edge k+1, so a second copy fed from `ser_out` continues the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load control, active low, level sensitive |
| sclk_a | input | 1 | Gated-clock pin A, interchangeable with B |
| sclk_b | input | 1 | Gated-clock pin B, interchangeable with A |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | W | Parallel data, bit i goes to stage i |
| ser_out | output | 1 | Last stage, true |
| ser_out_n | output | 1 | Last stage, inverted |

## Verification
The assertions assume that the pins are already synchronous to the system clock and stable between edges. They also assume that the pin used as an enable rises only while the other pin is high, and that `load_n` is released while the gated clock is low or in the same cycle as a deliberate rise.

The stimulus changes every input only at the falling system edge. It raises an enable only while the clock pin is high, or with the gated clock already high. It releases the load with both pins low, except in the single directed case that checks a rise coinciding with release.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } piso_op_e;

  // Level of the gated shift clock: either pin high forces it high.
  function automatic logic gated_level(input logic pin_a, input logic pin_b);
    return pin_a | pin_b;
  endfunction

  // 0-to-1 change between the previous and current sample.
  function automatic logic rose(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // Source bit for stage idx on a shift.
  function automatic logic shift_src(input int idx, input logic sin, input logic below);
    return (idx == 0) ? sin : below;
  endfunction

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load_n,
  input  logic     sclk_a,
  input  logic     sclk_b,
  output piso_op_e op,
  output logic     shift_pulse,
  output logic     gclk_hist
);

  logic gclk_now;
  logic load_hist;   // 1 when load_n was high last cycle
  logic gclk_rise;

  assign gclk_now  = gated_level(sclk_a, sclk_b);
  assign gclk_rise = rose(gclk_now, gclk_hist);

  always_ff @(posedge clk) begin
    if (rst) begin
      gclk_hist <= 1'b0;
      load_hist <= 1'b1;
    end else begin
      gclk_hist <= gclk_now;
      load_hist <= load_n;
    end
  end

  // A rise only counts once load has been released for a full cycle.
  assign shift_pulse = load_n & load_hist & gclk_rise;

  always_comb begin
    if (!load_n)          op = OP_LOAD;
    else if (shift_pulse) op = OP_SHIFT;
    else                  op = OP_HOLD;
  end

endmodule

// File: rtl/piso_chain.sv
module piso_chain
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  piso_op_e     op,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] stage_q,
  output logic         last_n_q
);

  localparam int TOP = W - 1;

  logic [W-1:0] stage_d;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic below;
    if (i == 0) begin : g_first
      assign below = ser_in;
    end else begin : g_rest
      assign below = stage_q[i-1];
    end

    always_comb begin
      unique case (op)
        OP_LOAD:  stage_d[i] = par_in[i];
        OP_SHIFT: stage_d[i] = shift_src(i, ser_in, below);
        default:  stage_d[i] = stage_q[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= 1'b0;
      else     stage_q[i] <= stage_d[i];
    end
  end

  // Inverted copy of the last stage, kept in its own flop.
  always_ff @(posedge clk) begin
    if (rst) last_n_q <= 1'b1;
    else     last_n_q <= ~stage_d[TOP];
  end

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic         sclk_a,
  input  logic         sclk_b,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic         ser_out,
  output logic         ser_out_n
);

  localparam int TOP = W - 1;

  piso_op_e     op;
  logic         shift_pulse;
  logic         gclk_hist;
  logic [W-1:0] stage_q;
  logic         last_n_q;

  piso_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .load_n      (load_n),
    .sclk_a      (sclk_a),
    .sclk_b      (sclk_b),
    .op          (op),
    .shift_pulse (shift_pulse),
    .gclk_hist   (gclk_hist)
  );

  piso_chain #(.W(W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .stage_q  (stage_q),
    .last_n_q (last_n_q)
  );

  assign ser_out   = stage_q[TOP];
  assign ser_out_n = last_n_q;

endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load_n,
  input logic         sclk_a,
  input logic         sclk_b,
  input logic         ser_in,
  input logic [W-1:0] par_in,
  input logic         ser_out,
  input logic         ser_out_n,
  input logic         shift_pulse,
  input logic [W-1:0] stage_q
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ser_out == 1'b0 && ser_out_n == 1'b1)); // R1

  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> ser_out == $past(par_in[W-1])); // R2

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> stage_q[0] == $past(ser_in)); // R3

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> ser_out == $past(stage_q[W-2])); // R3

  AST_ENABLE_B_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sclk_b && $past(sclk_b)) |-> !shift_pulse); // R4

  AST_ENABLE_A_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sclk_a && $past(sclk_a)) |-> !shift_pulse); // R5

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    ser_out_n == !ser_out); // R6

  AST_NO_SHIFT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (load_n && !$past(load_n)) |-> !shift_pulse); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (load_n && !shift_pulse) |=> $stable(stage_q)); // R8

endmodule

bind piso_shift_reg piso_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load_n      (load_n),
  .sclk_a      (sclk_a),
  .sclk_b      (sclk_b),
  .ser_in      (ser_in),
  .par_in      (par_in),
  .ser_out     (ser_out),
  .ser_out_n   (ser_out_n),
  .shift_pulse (shift_pulse),
  .stage_q     (stage_q)
);

// File: tb/sim_piso_shift_reg.sv
module sim_piso_shift_reg;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int WATCHDOG = 200000;

  logic         clk = 1'b0;
  logic         rst;
  logic         load_n;
  logic         sclk_a;
  logic         sclk_b;
  logic         ser_in;
  logic [W-1:0] par0;
  logic [W-1:0] par1;
  logic         out0, out0_n, out1, out1_n;

  int n_chk = 0;
  int n_bad = 0;
  bit swap = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_shift_reg #(.W(W)) u0 (
    .clk(clk), .rst(rst), .load_n(load_n), .sclk_a(sclk_a), .sclk_b(sclk_b),
    .ser_in(ser_in), .par_in(par0), .ser_out(out0), .ser_out_n(out0_n));

  // Second copy chained from the first (R9).
  piso_shift_reg #(.W(W)) u1 (
    .clk(clk), .rst(rst), .load_n(load_n), .sclk_a(sclk_a), .sclk_b(sclk_b),
    .ser_in(out0), .par_in(par1), .ser_out(out1), .ser_out_n(out1_n));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Drive the clock-role pin and enable-role pin; swap picks which is which.
  task automatic pins(input logic cpin, input logic epin);
    if (swap) begin sclk_a = epin; sclk_b = cpin; end
    else      begin sclk_a = cpin; sclk_b = epin; end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    logic [W-1:0] v, s, w;
    rst = 1'b1; load_n = 1'b1; sclk_a = 1'b0; sclk_b = 1'b0; ser_in = 1'b0;
    par0 = '1; par1 = '1;
    step(); step();
    rst = 1'b0;
    chk("R1 reset out", out0, 1'b0);
    chk("R1 reset out_n", out0_n, 1'b1);

    // Sweep every byte value; pin roles alternate (R5).
    for (int vi = 0; vi < 256; vi++) begin
      v = W'(vi);
      w = ~v;
      s = W'(vi * 37 + 11);
      swap = v[0] ^ v[3];
      load_n = 1'b0; par0 = v; par1 = w;
      pins(v[1], 1'b0);
      step();
      chk("R2 load u0", out0, v[W-1]);
      chk("R2 load u1", out1, w[W-1]);
      chk("R6 compl u0", out0_n, ~out0);
      pins(1'b0, 1'b0);
      load_n = 1'b1;
      step();
      for (int k = 1; k <= 2*W-1; k++) begin
        ser_in = (k <= W) ? s[k-1] : 1'b0;
        pins(1'b1, 1'b0);
        step();
        if (k < W) begin
          chk(swap ? "R5 R3 u0 word" : "R3 u0 word", out0, v[W-1-k]);
          chk("R9 u1 word", out1, w[W-1-k]);
        end else begin
          chk("R9 u0 serial", out0, s[k-W]);
          chk("R9 u1 chained", out1, v[2*W-1-k]);
        end
        chk("R6 compl u0", out0_n, ~out0);
        chk("R6 compl u1", out1_n, ~out1);
        pins(1'b0, 1'b0);
        step();
        chk("R8 falling edge hold", out0, (k < W) ? v[W-1-k] : s[k-W]);
      end
    end

    // R4: enable held high blocks shifting while the clock pin toggles.
    swap = 1'b0;
    load_n = 1'b0; par0 = 8'hA5; pins(1'b0, 1'b0);
    step();
    load_n = 1'b1; step();
    pins(1'b1, 1'b0); step();          // shift: A5 bit6 = 0
    chk("R3 first shift", out0, 1'b0);
    pins(1'b1, 1'b1); step();          // enable rises while clock high
    for (int t = 0; t < 4; t++) begin
      pins(1'(t % 2), 1'b1);
      step();
      chk("R4 enable blocks", out0, 1'b0);
    end
    pins(1'b1, 1'b0); step();          // gated clock stays high, no rise
    chk("R8 steady high hold", out0, 1'b0);
    pins(1'b0, 1'b0); step();
    pins(1'b1, 1'b0); step();          // A5 bit5 = 1
    chk("R3 shift after enable", out0, 1'b1);

    // R7: rise coinciding with load release does not shift.
    pins(1'b0, 1'b0); load_n = 1'b0; par0 = 8'h80; step();
    load_n = 1'b1; pins(1'b1, 1'b0); step();
    chk("R7 no shift on release", out0, 1'b1);
    pins(1'b0, 1'b0); step();
    pins(1'b1, 1'b0); step();
    chk("R7 next edge shifts", out0, 1'b0);

    // R8: steady high gated clock holds for several cycles.
    pins(1'b0, 1'b0); load_n = 1'b0; par0 = 8'h40; step();
    chk("R2 load 40", out0, 1'b0);
    load_n = 1'b1; step();
    pins(1'b1, 1'b0); step();
    chk("R3 shift 40", out0, 1'b1);
    for (int t = 0; t < 5; t++) begin
      step();
      chk("R8 hold high", out0, 1'b1);
    end
    pins(1'b0, 1'b0); step();
    chk("R8 hold fall", out0, 1'b1);

    // R2: output follows par_in while load low, clock pins toggling.
    load_n = 1'b0;
    for (int t = 0; t < 8; t++) begin
      par0 = W'(t * 53 + 7);
      swap = t[0];
      pins(t[1], t[2]);
      step();
      chk("R2 follow", out0, par0[W-1]);
      chk("R6 follow compl", out0_n, ~par0[W-1]);
    end

    // R1: reset mid-run.
    swap = 1'b0; pins(1'b0, 1'b0);
    par0 = 8'hFF; step();
    rst = 1'b1; step();
    rst = 1'b0;
    chk("R1 midrun out", out0, 1'b0);
    chk("R1 midrun out_n", out0_n, 1'b1);
    load_n = 1'b1;
    step();
    chk("R1 stays clear", out0, 1'b0);

    summary();
  end

endmodule